// File: doc/BRIEF.md
# Multi-slot Step Ramp Generator

This block produces a 12-bit code sequence that walks from a start value toward an end value in fixed increments. The walk moves up or down, and each move is one step of 0 to 15 codes. It sits between a pacing timer and a converter's data input. The pacing logic raises an advance strobe whenever the converter should take a new value. The block answers each strobe with a one-cycle valid strobe and the new code.

The block holds four configuration slots. Each slot has its own trigger bit. A trigger selects its slot and loads that slot's start value, and a trigger that arrives during a run restarts the walk. When more than one trigger is raised in the same cycle, the slot with the lowest index wins.

The walk never overshoots: a step that would pass the end value lands exactly on it. Each arrival at the end value gives a one-cycle completion pulse. After arrival, a slot either halts or reloads its start value on the next advance and runs the walk again. A slot with a step of zero holds its start value for as long as it runs.

Top module: `step_ramp_gen`

## Requirements
- R1: After a synchronous active-low reset, `code_o` is 0 and `valid_o` and `done_o` are low.
- R2: Each slot takes a 30-bit word in `slot_cfg_i[s*30 +: 30]` with these fields: start value in bits 11:0, step in bits 15:12, end value in bits 27:16, direction in bit 28 (0 counts up, 1 counts down) and repeat in bit 29. A trigger bit set in a cycle makes the next cycle show that slot's start value on `code_o`, with `valid_o` high and `done_o` low. When several trigger bits are set together, the lowest index wins.
- R3: While a slot counts up, each advance strobe raises `code_o` by the step and pulses `valid_o` in the next cycle.
- R4: While a slot counts down, each advance strobe lowers `code_o` by the step.
- R5: A move that would reach or pass the end value sets `code_o` to the end value exactly and pulses `done_o` together with `valid_o` for one cycle. This also applies when the start value already lies beyond the end value in the direction of travel.
- R6: If repeat is 0, the run halts when it arrives at the end value. Later advance strobes produce no `valid_o`, and `code_o` keeps the end value.
- R7: If repeat is 1, the first advance after arrival reloads the start value without `done_o`. The walk then continues, and `done_o` pulses again on every arrival.
- R8: With a step of 0, every advance returns the start value with `valid_o` high, and `done_o` never pulses.
- R9: A trigger during a run restarts from the start value of the triggered slot, whether that is the same slot or another one. When a trigger and an advance come in the same cycle, the trigger wins.
- R10: An advance strobe with no run in progress, and any cycle with no advance and no trigger, leaves `valid_o` low and `code_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_cfg_i | input | 120 | Four packed 30-bit slot configuration words, slot 0 in the low bits |
| trig_i | input | 4 | Per-slot start trigger, one bit per slot |
| adv_i | input | 1 | Advance strobe from the pacing logic |
| code_o | output | 12 | Current ramp code |
| valid_o | output | 1 | One-cycle strobe marking a new code |
| done_o | output | 1 | One-cycle pulse on each arrival at the end value |

## Verification
The hardest conditions to reach are the clamped arrivals: a step that does not divide the span, and a start value that already lies beyond the end value. Neither occurs on a clean ramp. The stimulus programs slots with spans of 10 against a step of 15 and 6 against a step of 7, and with inverted start and end values in both directions. It then checks that exactly one advance lands on the end value. Restart and priority are reached by raising triggers in the middle of a run, by raising several triggers at once, and by raising a trigger together with an advance.

// File: rtl/ramp_pkg.sv
// Package: shared widths, field positions and the decoded slot configuration.
// Assumes the configuration word layout given in the brief (R2).
package ramp_pkg;
    localparam int CODE_W    = 12;
    localparam int STEP_W    = 4;
    localparam int STEP_LSB  = CODE_W;
    localparam int END_LSB   = STEP_LSB + STEP_W;
    localparam int DIR_BIT   = END_LSB + CODE_W;
    localparam int RPT_BIT   = DIR_BIT + 1;
    localparam int CFG_W     = RPT_BIT + 1;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic              rpt;
        logic              down;
        code_t             stop;
        logic [STEP_W-1:0] inc;
        code_t             base;
    } ramp_cfg_t;

    // Split one raw configuration word into its fields.
    function automatic ramp_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        ramp_cfg_t c;
        c.base = w[STEP_LSB-1:0];
        c.inc  = w[END_LSB-1:STEP_LSB];
        c.stop = w[DIR_BIT-1:END_LSB];
        c.down = w[DIR_BIT];
        c.rpt  = w[RPT_BIT];
        return c;
    endfunction
endpackage

// File: rtl/ramp_trig_arb.sv
// Module: fixed-priority pick among slot triggers, lowest index first.
// Assumes NUM_SLOTS >= 2. Purely combinational.
module ramp_trig_arb #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);
    // Scan from the top so that the lowest set index is the last to assign.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (req[i]) idx = i[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/ramp_next_calc.sv
// Module: next-code computation for one step, with clamp at the end value.
// Assumes cur, stop and inc come from the active slot. A zero step holds the code and never reports arrival.
module ramp_next_calc
    import ramp_pkg::*;
(
    input  code_t             cur,
    input  code_t             stop,
    input  logic [STEP_W-1:0] inc,
    input  logic              down,
    output code_t             nxt,
    output logic              hit
);
    code_t inc_ext;
    code_t gap;

    assign inc_ext = {{(CODE_W-STEP_W){1'b0}}, inc};

    // Move by one step, or land on the end value if the step would reach or pass it.
    always_comb begin
        nxt = cur;
        hit = 1'b0;
        gap = '0;
        if (inc != '0) begin
            if (!down) begin
                if (cur >= stop) begin
                    hit = 1'b1;
                end else begin
                    gap = stop - cur;
                    hit = (gap <= inc_ext);
                end
                nxt = hit ? stop : cur + inc_ext;
            end else begin
                if (cur <= stop) begin
                    hit = 1'b1;
                end else begin
                    gap = cur - stop;
                    hit = (gap <= inc_ext);
                end
                nxt = hit ? stop : cur - inc_ext;
            end
        end
    end
endmodule

// File: rtl/ramp_cfg_bank.sv
// Module: unpacks the flat configuration bus into one decoded record per slot.
// Assumes the words are packed side by side, slot 0 in the low bits.
module ramp_cfg_bank
    import ramp_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS*CFG_W-1:0] flat,
    output ramp_cfg_t                  cfg [NUM_SLOTS]
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Decode the word of slot s.
        assign cfg[s] = unpack_cfg(flat[s*CFG_W +: CFG_W]);
    end
endmodule

// File: rtl/step_ramp_gen.sv
// Module: multi-slot step ramp generator, the top of the block.
// Only the index of the running slot is stored. Its fields are read live, so software is
// expected to leave a running slot's word unchanged. Outputs are registered.
module step_ramp_gen
    import ramp_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS*CFG_W-1:0] slot_cfg_i,
    input  logic [NUM_SLOTS-1:0]       trig_i,
    input  logic                       adv_i,
    output logic [CODE_W-1:0]          code_o,
    output logic                       valid_o,
    output logic                       done_o
);
    ramp_cfg_t        cfg [NUM_SLOTS];
    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] sel_q;
    logic             active_q;
    logic             wrap_q;
    code_t            code_q;
    logic             valid_q;
    logic             done_q;
    ramp_cfg_t        cur_cfg;
    ramp_cfg_t        new_cfg;
    code_t            nxt_code;
    logic             nxt_hit;

    ramp_cfg_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
        .flat (slot_cfg_i),
        .cfg  (cfg)
    );

    ramp_trig_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
        .req  (trig_i),
        .any  (win_any),
        .idx  (win_idx)
    );

    assign cur_cfg = cfg[sel_q];
    assign new_cfg = cfg[win_idx];

    ramp_next_calc u_calc (
        .cur  (code_q),
        .stop (cur_cfg.stop),
        .inc  (cur_cfg.inc),
        .down (cur_cfg.down),
        .nxt  (nxt_code),
        .hit  (nxt_hit)
    );

    // Run control: a trigger loads a slot, an advance steps, reloads or halts the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wrap_q   <= 1'b0;
            sel_q    <= '0;
            code_q   <= '0;
            valid_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            if (win_any) begin
                active_q <= 1'b1;
                wrap_q   <= 1'b0;
                sel_q    <= win_idx;
                code_q   <= new_cfg.base;
                valid_q  <= 1'b1;
            end else if (adv_i && active_q) begin
                valid_q <= 1'b1;
                if (wrap_q) begin
                    wrap_q <= 1'b0;
                    code_q <= cur_cfg.base;
                end else begin
                    code_q <= nxt_code;
                    if (nxt_hit) begin
                        done_q <= 1'b1;
                        if (cur_cfg.rpt) wrap_q   <= 1'b1;
                        else             active_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign code_o  = code_q;
    assign valid_o = valid_q;
    assign done_o  = done_q;
endmodule

// File: rtl/ramp_chk.sv
// Module: protocol checker for the ramp generator, attached by bind.
// Assumes it sees the top's ports and its run flag.
module ramp_chk #(
    parameter int NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] trig_i,
    input logic                 adv_i,
    input logic [11:0]          code_o,
    input logic                 valid_o,
    input logic                 done_o,
    input logic                 active_q
);
    // R2
    trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i != '0) |=> (valid_o && !done_o));

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i == '0 && !adv_i) |=> (!valid_o && $stable(code_o)));

    // R10
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i == '0 && !active_q) |=> !valid_o);

    // R5
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);

    // R6
    halt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> done_o);
endmodule

bind step_ramp_gen ramp_chk #(.NUM_SLOTS(NUM_SLOTS)) u_ramp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig_i),
    .adv_i    (adv_i),
    .code_o   (code_o),
    .valid_o  (valid_o),
    .done_o   (done_o),
    .active_q (active_q)
);

// File: tb/step_ramp_gen_bench.sv
`timescale 1ns/100ps
// Directed bench for step_ramp_gen: one task per scenario, each checking its own results.
module step_ramp_gen_bench;
    localparam int NS = 4;
    localparam int CW = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS*CW-1:0]  cfg = '0;
    logic [NS-1:0]     trig = '0;
    logic              adv = 1'b0;
    logic [11:0]       code;
    logic              valid;
    logic              done;
    int                n_chk = 0;
    int                n_fail = 0;
    bit                finished = 1'b0;

    always #2.5 clk = ~clk;

    step_ramp_gen u_step_ramp_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_cfg_i (cfg),
        .trig_i     (trig),
        .adv_i      (adv),
        .code_o     (code),
        .valid_o    (valid),
        .done_o     (done)
    );

    // Program slot s: start, step, end, direction (1 = down), repeat.
    task automatic set_slot(input int s, input int st, input int inc, input int en,
                            input bit dn, input bit rp);
        logic [CW-1:0] w;
        w = {rp, dn, en[11:0], inc[3:0], st[11:0]};
        cfg[s*CW +: CW] = w;
    endtask

    // Drive one cycle of inputs, then settle just after the edge.
    task automatic tick(input logic [NS-1:0] t, input bit a);
        @(negedge clk);
        trig = t;
        adv  = a;
        @(posedge clk);
        #1;
        trig = '0;
        adv  = 1'b0;
    endtask

    // Compare valid, done and code against the expected values.
    task automatic expect_out(input string req, input bit v, input bit d, input int c);
        n_chk++;
        if (valid !== v || done !== d || code !== c[11:0]) begin
            n_fail++;
            $display("FAIL %s: valid/done/code = %0b/%0b/%0d, expected %0b/%0b/%0d",
                     req, valid, done, code, v, d, c);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 reset", 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        tick('0, 1); expect_out("R10 advance while idle", 0, 0, 0);
        tick('0, 0); expect_out("R10 quiet cycle", 0, 0, 0);
    endtask

    task automatic t_up();
        set_slot(0, 0, 3, 9, 0, 0);
        tick(4'b0001, 0); expect_out("R2 load slot0", 1, 0, 0);
        tick('0, 1);      expect_out("R3 up 3", 1, 0, 3);
        tick('0, 0);      expect_out("R10 hold between strobes", 0, 0, 3);
        tick('0, 1);      expect_out("R3 up 6", 1, 0, 6);
        tick('0, 1);      expect_out("R5 arrive 9", 1, 1, 9);
        tick('0, 1);      expect_out("R6 halted", 0, 0, 9);
        tick('0, 1);      expect_out("R6 still halted", 0, 0, 9);
    endtask

    task automatic t_down();
        set_slot(1, 100, 7, 80, 1, 0);
        tick(4'b0010, 0); expect_out("R2 load slot1", 1, 0, 100);
        tick('0, 1);      expect_out("R4 down 93", 1, 0, 93);
        tick('0, 1);      expect_out("R4 down 86", 1, 0, 86);
        tick('0, 1);      expect_out("R5 clamp down 80", 1, 1, 80);
        tick('0, 1);      expect_out("R6 halted down", 0, 0, 80);
    endtask

    task automatic t_clamp();
        set_slot(2, 10, 15, 20, 0, 0);
        tick(4'b0100, 0); expect_out("R2 load slot2", 1, 0, 10);
        tick('0, 1);      expect_out("R5 clamp up 20", 1, 1, 20);
        set_slot(2, 50, 2, 20, 0, 0);
        tick(4'b0100, 0); expect_out("R2 load beyond end", 1, 0, 50);
        tick('0, 1);      expect_out("R5 start past end up", 1, 1, 20);
        set_slot(3, 5, 4, 30, 1, 0);
        tick(4'b1000, 0); expect_out("R2 load slot3", 1, 0, 5);
        tick('0, 1);      expect_out("R5 start past end down", 1, 1, 30);
    endtask

    task automatic t_repeat();
        set_slot(3, 5, 5, 15, 0, 1);
        tick(4'b1000, 0); expect_out("R2 load repeat", 1, 0, 5);
        tick('0, 1);      expect_out("R7 lap1 10", 1, 0, 10);
        tick('0, 1);      expect_out("R7 lap1 end", 1, 1, 15);
        tick('0, 1);      expect_out("R7 reload", 1, 0, 5);
        tick('0, 1);      expect_out("R7 lap2 10", 1, 0, 10);
        tick('0, 1);      expect_out("R7 lap2 end", 1, 1, 15);
    endtask

    task automatic t_zero();
        set_slot(0, 42, 0, 100, 0, 1);
        tick(4'b0001, 0); expect_out("R8 load", 1, 0, 42);
        for (int i = 0; i < 4; i++) begin
            tick('0, 1); expect_out("R8 hold start", 1, 0, 42);
        end
    endtask

    task automatic t_restart();
        set_slot(0, 0, 3, 9, 0, 0);
        set_slot(2, 200, 1, 210, 0, 0);
        tick(4'b0001, 0); expect_out("R9 load", 1, 0, 0);
        tick('0, 1);      expect_out("R9 step", 1, 0, 3);
        tick('0, 1);      expect_out("R9 step", 1, 0, 6);
        tick(4'b0001, 0); expect_out("R9 restart same slot", 1, 0, 0);
        tick('0, 1);      expect_out("R9 step after restart", 1, 0, 3);
        tick(4'b0100, 0); expect_out("R9 switch slot", 1, 0, 200);
        tick('0, 1);      expect_out("R9 step new slot", 1, 0, 201);
    endtask

    task automatic t_prio();
        set_slot(1, 100, 7, 80, 1, 0);
        set_slot(2, 200, 1, 210, 0, 0);
        set_slot(3, 5, 5, 15, 0, 1);
        tick(4'b1010, 0); expect_out("R2 priority 1 over 3", 1, 0, 100);
        tick(4'b1100, 0); expect_out("R2 priority 2 over 3", 1, 0, 200);
        tick(4'b1000, 1); expect_out("R9 trigger beats advance", 1, 0, 5);
        tick('0, 1);      expect_out("R9 advance after load", 1, 0, 10);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_up();
        t_down();
        t_clamp();
        t_repeat();
        t_zero();
        t_restart();
        t_prio();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule